// File: doc/BRIEF.md
# Multi-Port Register Host Slave

This block is the host-facing register port of an eight-port controller. A host processor drives an 11-bit address, a read/write select and an active-low chip select, and the slave answers with an active-low acknowledge pulse. Read data comes out on a 32-bit output that is enabled only while a read is in progress. Write data is taken from a separate 32-bit input. The chip select and the read/write select may change with no fixed relation to the slave clock, so both are resynchronised before they are used.

Each address has two parts. The upper three bits name a port and the lower eight bits name a register offset. Four control words per port sit at offsets 0x00 to 0x03, and any host may read or write them. An event counter per port sits at offset 0x40. Each counter counts the pulses on its own event input, and the host can only read it. Six management words sit at offsets 0x80 to 0x85 and exist only on port 0. Four global words sit at offsets 0xC0 to 0xC3, and every port number reaches the same four words. All other addresses are unmapped, and a read of one returns zero.

Top module: `hostreg_slave`

## Requirements
- R1: An access starts when the synchronised chip select (cs_n) is low. If rw is 1 the access is a read. If rw is 0 the access is a write.
- R2: Each access produces exactly one acknowledge pulse. ack_n is low for one clock cycle and then returns high.
- R3: If cs_n stays low after the acknowledge, no further access starts. A new access waits until cs_n has been seen high.
- R4: addr[10:8] selects the port and addr[7:0] selects the offset. Each port has its own control words at offsets 0x00 to 0x03, and these can be read and written.
- R5: Offsets 0xC0 to 0xC3 are global words. The port field is ignored for these offsets, so a write on any port can be read back on any other port.
- R6: Offsets 0x80 to 0x85 are management words that respond only when the port field is 0. A write to one of them on any other port leaves the port-0 word unchanged, and a read on any other port returns 0.
- R7: Offset 0x40 on port p reads a 32-bit counter. The counter increments once for each clock cycle in which stat_evt[p] is high. Host writes to this offset are ignored.
- R8: A read of an unmapped or invalid address returns 0 and is still acknowledged normally. A write to such an address has no effect.
- R9: data_oe is 1 only during a read. It is set together with the acknowledge and cleared once cs_n has been seen high. During a write, data_oe stays 0.
- R10: After reset, ack_n is 1, data_oe is 0, and every register and counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| rw | input | 1 | Read/write select: 1 means read, 0 means write |
| addr | input | 11 | Address: port number in bits 10:8, offset in bits 7:0 |
| data_in | input | 32 | Write data from the host |
| data_out | output | 32 | Read data to the host |
| data_oe | output | 1 | Output enable for data_out |
| ack_n | output | 1 | Acknowledge, active low, one cycle long |
| stat_evt | input | 8 | One event strobe per port, feeding that port's counter |

## Verification
The same offset is written on two different ports and read back. This separates port-local storage from shared storage. The global offsets and the management offsets are then used on port 0 and on other ports. This shows whether the port field is ignored, honoured or rejected, as each offset requires. Counter reads are made after uneven event bursts on two ports and after a host write to the counter, which separates counting from storing. Chip select is held low for several cycles after each acknowledge, and the enable is checked after release, which shows whether an access is repeated and whether the bus is left driven.

// File: rtl/hostreg_slave.sv
module hostreg_slave #(
  parameter int PORTS  = 8,
  parameter int AW     = 11,
  parameter int DW     = 32,
  parameter int CTRL_N = 4,
  parameter int MGMT_N = 6,
  parameter int GLB_N  = 4,
  parameter logic [7:0] CTRL_BASE = 8'h00,
  parameter logic [7:0] STAT_BASE = 8'h40,
  parameter logic [7:0] MGMT_BASE = 8'h80,
  parameter logic [7:0] GLB_BASE  = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic             ack_n,
  input  logic [PORTS-1:0] stat_evt
);
  localparam int OFS_W  = 8;
  localparam int PORT_W = AW - OFS_W;
  localparam int PI_W   = PORTS > 1 ? $clog2(PORTS) : 1;
  localparam int CI_W   = CTRL_N > 1 ? $clog2(CTRL_N) : 1;
  localparam int MI_W   = MGMT_N > 1 ? $clog2(MGMT_N) : 1;
  localparam int GI_W   = GLB_N > 1 ? $clog2(GLB_N) : 1;

  logic [1:0] cs_sync, rw_sync;
  logic       busy;
  wire        cs_s = cs_sync[1];
  wire        rw_s = rw_sync[1];

  logic [DW-1:0] ctrl_q [PORTS][CTRL_N];
  logic [DW-1:0] stat_q [PORTS];
  logic [DW-1:0] mgmt_q [MGMT_N];
  logic [DW-1:0] glb_q  [GLB_N];

  wire [PORT_W-1:0] port = addr[AW-1:OFS_W];
  wire [OFS_W-1:0]  ofs  = addr[OFS_W-1:0];
  wire [OFS_W-1:0]  rel_c = ofs - CTRL_BASE;
  wire [OFS_W-1:0]  rel_m = ofs - MGMT_BASE;
  wire [OFS_W-1:0]  rel_g = ofs - GLB_BASE;

  wire [PI_W-1:0] port_i = PI_W'(port);
  wire [CI_W-1:0] ci = CI_W'(rel_c);
  wire [MI_W-1:0] mi = MI_W'(rel_m);
  wire [GI_W-1:0] gi = GI_W'(rel_g);

  wire port_ok  = int'(port) < PORTS;
  wire ctrl_hit = port_ok && (int'(rel_c) < CTRL_N);
  wire stat_hit = port_ok && (ofs == STAT_BASE);
  wire mgmt_hit = (port == '0) && (int'(rel_m) < MGMT_N);
  wire glb_hit  = int'(rel_g) < GLB_N;

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (ctrl_hit)      rd_val = ctrl_q[port_i][ci];
    else if (stat_hit) rd_val = stat_q[port_i];
    else if (mgmt_hit) rd_val = mgmt_q[mi];
    else if (glb_hit)  rd_val = glb_q[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= 2'b11;
      rw_sync  <= 2'b11;
      busy     <= 1'b0;
      ack_n    <= 1'b1;
      data_oe  <= 1'b0;
      data_out <= '0;
      for (int p = 0; p < PORTS; p++)
        for (int r = 0; r < CTRL_N; r++) ctrl_q[p][r] <= '0;
      for (int r = 0; r < MGMT_N; r++) mgmt_q[r] <= '0;
      for (int r = 0; r < GLB_N; r++)  glb_q[r]  <= '0;
    end else begin
      cs_sync <= {cs_sync[0], cs_n};
      rw_sync <= {rw_sync[0], rw};
      ack_n   <= 1'b1;
      if (!busy) begin
        if (!cs_s) begin
          busy  <= 1'b1;
          ack_n <= 1'b0;
          if (rw_s) begin
            data_out <= rd_val;
            data_oe  <= 1'b1;
          end else if (ctrl_hit) ctrl_q[port_i][ci] <= data_in;
          else if (mgmt_hit)     mgmt_q[mi]         <= data_in;
          else if (glb_hit)      glb_q[gi]          <= data_in;
        end
      end else if (cs_s) begin
        busy    <= 1'b0;
        data_oe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PORTS; p++) stat_q[p] <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++)
        if (stat_evt[p]) stat_q[p] <= stat_q[p] + 1'b1;
    end
  end

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);
  assert_ack_needs_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> !$past(cs_s));
  assert_no_reaccess_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_s && ack_n) |=> ack_n);
  assert_bus_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_s) |=> !data_oe);
  assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !cs_s) |-> rw_s);

  for (genvar p = 0; p < PORTS; p++) begin : g_stat_chk
    assert_stat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_q[p]) |-> (stat_q[p] == $past(stat_q[p]) + 1'b1) && $past(stat_evt[p]));
  end
endmodule

// File: tb/hostreg_slave_bench.sv
module hostreg_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rw = 1'b1;
  logic [10:0] addr = '0;
  logic [31:0] data_in = '0;
  logic [31:0] data_out;
  logic        data_oe;
  logic        ack_n;
  logic [7:0]  stat_evt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  hostreg_slave u_hostreg_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ack_n(ack_n), .stat_evt(stat_evt)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ack_n) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected acknowledge", 32'd1, 32'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[32]) begin
          check(data_oe == 1'b1, {t, " read enable"}, {31'd0, data_oe}, 32'd1);
          check(data_out == e[31:0], t, data_out, e[31:0]);
        end else begin
          check(data_oe == 1'b0, {t, " write enable R9"}, {31'd0, data_oe}, 32'd0);
        end
      end
    end
  end

  task automatic access(input bit rd, input logic [10:0] a, input logic [31:0] wd,
                        input logic [31:0] exp, input string tag);
    int waited;
    int extra;
    @(negedge clk);
    addr = a; rw = rd; data_in = wd; cs_n = 1'b0;
    exp_q.push_back({rd, exp});
    tag_q.push_back(tag);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (ack_n && waited < 50);
    check(!ack_n, {tag, " R1 acknowledge seen"}, {31'd0, ack_n}, 32'd0);
    extra = 0;
    @(negedge clk);
    check(ack_n, {tag, " R2 one-cycle pulse"}, {31'd0, ack_n}, 32'd1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!ack_n) extra++;
    end
    check(extra == 0, {tag, " R3 no re-access"}, extra, 32'd0);
    cs_n = 1'b1; rw = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(data_oe == 1'b0, {tag, " R9 bus released"}, {31'd0, data_oe}, 32'd0);
  endtask

  task automatic pulse_evt(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); stat_evt[p] = 1'b1;
      @(negedge clk); stat_evt[p] = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ack_n == 1'b1, "R10 ack idle in reset", {31'd0, ack_n}, 32'd1);
    check(data_oe == 1'b0, "R10 enable off in reset", {31'd0, data_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    access(1, 11'h001, 0, 32'h0, "R10 control cleared");
    access(1, 11'h740, 0, 32'h0, "R10 counter cleared");
    access(0, 11'h301, 32'hA5A5_0301, 0, "R1 write port3");
    access(0, 11'h501, 32'h5A5A_0501, 0, "R4 write port5");
    access(1, 11'h301, 0, 32'hA5A5_0301, "R4 read port3");
    access(1, 11'h501, 0, 32'h5A5A_0501, "R4 read port5");
    access(1, 11'h001, 0, 32'h0, "R4 port0 untouched");
    access(0, 11'h003, 32'h0000_0C03, 0, "R4 write last ctrl");
    access(1, 11'h003, 0, 32'h0000_0C03, "R4 read last ctrl");
    access(0, 11'h6C2, 32'hC0DE_0006, 0, "R5 global write port6");
    access(1, 11'h1C2, 0, 32'hC0DE_0006, "R5 global read port1");
    access(1, 11'h0C2, 0, 32'hC0DE_0006, "R5 global read port0");
    access(0, 11'h082, 32'h1234_5678, 0, "R6 mgmt write port0");
    access(1, 11'h082, 0, 32'h1234_5678, "R6 mgmt read port0");
    access(0, 11'h482, 32'hDEAD_BEEF, 0, "R6 mgmt write port4");
    access(1, 11'h082, 0, 32'h1234_5678, "R6 mgmt unchanged");
    access(1, 11'h482, 0, 32'h0, "R6 mgmt port4 reads zero");
    pulse_evt(2, 5);
    pulse_evt(7, 3);
    access(1, 11'h240, 0, 32'd5, "R7 count port2");
    access(1, 11'h740, 0, 32'd3, "R7 count port7");
    access(1, 11'h040, 0, 32'd0, "R7 count port0");
    access(0, 11'h240, 32'h0000_FFFF, 0, "R7 write counter");
    access(1, 11'h240, 0, 32'd5, "R7 write ignored");
    access(1, 11'h3FF, 0, 32'h0, "R8 unmapped top");
    access(1, 11'h210, 0, 32'h0, "R8 unmapped gap");
    access(0, 11'h110, 32'hFFFF_FFFF, 0, "R8 unmapped write");
    access(1, 11'h110, 0, 32'h0, "R8 unmapped still zero");
    access(1, 11'h301, 0, 32'hA5A5_0301, "R8 ctrl intact");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 every access acknowledged", exp_q.size(), 32'd0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule